// File: doc/BRIEF.md
# Privilege Check and Program-Interrupt Entry

This block sits just ahead of execution and judges each decoded instruction as it issues. From the instruction's operation class, its raw word and the live machine state register (MSR), it chooses one of three outcomes. The instruction may proceed. It may be turned into a program interrupt. Or, if it is a permitted stop request, it may freeze the core. Once frozen, the block lets nothing further through until reset.

When an interrupt is taken, the block records where it happened and what state the machine was in. The issuing address goes to save register 0. The pre-interrupt MSR goes to save register 1, with a single cause bit added to that copy. The live MSR is then forced to a fixed supervisor state, and the next fetch address is redirected to the interrupt vector in place of whatever the instruction computed. When an instruction proceeds normally, the block forwards the instruction's own next address and any MSR value the instruction produced.

MSR fields and cause bits use big-endian numbering (bit 0 is the most significant bit of the register). Their positions are parameters.

Top module: `priv_trap_unit`

## Requirements
- R1: A synchronous reset clears `halted`, loads the MSR from `MSR_RST` and clears both save registers.
- R2: Operation classes are coded 0 other, 1 stop, 2 read-MSR, 3 write-MSR, 4 write-MSR-doubleword, 5 interrupt-return, 6 read-SPR and 7 write-SPR. Classes 1 to 5 are always privileged. Classes 6 and 7 are privileged only when instruction bit 20 is set, where bit 0 is the least significant bit of the word. A privileged instruction issued with MSR problem-state bit (big-endian 49) set takes an interrupt, with the privileged cause bit (big-endian 45, value 0x40000) set in save register 1.
- R3: An instruction flagged as mismatched takes an interrupt with the illegal cause bit (big-endian 44, value 0x80000) set in save register 1.
- R4: On interrupt entry, save register 0 receives the issuing address. Save register 1 receives the pre-interrupt MSR, which differs from it only in the cause bit.
- R5: On interrupt entry, the MSR bits at big-endian positions 5, 29, 30, 31, 38, 40, 48, 49, 50, 52, 55, 58, 59, 61 and 62 are cleared, bits 0 and 63 are set, and all other bits keep their value.
- R6: `next_pc` is 0x700 when an interrupt is taken, the issued next address when the instruction proceeds, and the issuing address otherwise. `trap_taken` and `exec_go` are never both high.
- R7: The privilege check comes before the stop check. A stop request in problem state takes a privileged interrupt and does not halt. A stop request in supervisor state sets `halted` and does not proceed.
- R8: `halted` is sticky. While it is set, no instruction proceeds or takes an interrupt, and the MSR and save registers hold their values.
- R9: An MSR write carried with an issue is applied at the next edge only when that instruction proceeds. On an interrupt or while halted it is ignored.
- R10: A privileged instruction that is also mismatched reports the privileged cause in problem state and the illegal cause in supervisor state.
- R11: A cycle with `issue_valid` low changes no state and asserts neither `exec_go` nor `trap_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | An instruction is issued this cycle |
| issue_op | input | 3 | Operation class code |
| issue_insn | input | 32 | Raw instruction word |
| issue_cia | input | 64 | Address of the issued instruction |
| issue_nia | input | 64 | Next address computed by the instruction |
| issue_mismatch | input | 1 | Decoded operation disagrees with the expected instruction |
| msr_wr_en | input | 1 | The instruction writes the MSR |
| msr_wr_data | input | 64 | MSR value written by the instruction |
| next_pc | output | 64 | Next fetch address |
| exec_go | output | 1 | Instruction may proceed |
| trap_taken | output | 1 | Program interrupt taken this cycle |
| msr_q | output | 64 | Live MSR |
| srr0_q | output | 64 | Save register 0 |
| srr1_q | output | 64 | Save register 1 |
| halted | output | 1 | Sticky stop flag |

## Verification
The bench keeps every default bit position, vector and the 64-bit width. It overrides `MSR_RST` to 0xC000, so the core leaves reset in problem state with external interrupts enabled. A privileged interrupt is therefore reachable on the very first issue, and the reset image contains bits that entry must clear. Random issues then mix MSR writes that toggle the problem-state bit with SPR moves whose bit 20 varies, so both privilege outcomes of every class occur.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

  typedef enum logic [2:0] {
    OPC_OTHER  = 3'd0,
    OPC_STOP   = 3'd1,
    OPC_RDMSR  = 3'd2,
    OPC_WRMSR  = 3'd3,
    OPC_WRMSRD = 3'd4,
    OPC_IRET   = 3'd5,
    OPC_RDSPR  = 3'd6,
    OPC_WRSPR  = 3'd7
  } opc_e;

  typedef enum logic [2:0] {
    ACT_NONE      = 3'd0,
    ACT_RUN       = 3'd1,
    ACT_HALT      = 3'd2,
    ACT_TRAP_PRIV = 3'd3,
    ACT_TRAP_ILL  = 3'd4
  } act_e;

  function automatic logic is_trap(act_e a);
    return (a == ACT_TRAP_PRIV) || (a == ACT_TRAP_ILL);
  endfunction

endpackage

// File: rtl/priv_classify.sv
module priv_classify
  import priv_trap_pkg::*;
#(
  parameter int IW          = 32,
  parameter int SPR_SEL_BIT = 20
) (
  input  logic          valid,
  input  logic [2:0]    op,
  input  logic [IW-1:0] insn,
  input  logic          user_mode,
  input  logic          mismatch,
  input  logic          halted,
  output logic          priv_op,
  output act_e          act
);

  opc_e opc;
  assign opc = opc_e'(op);

  function automatic logic needs_priv(opc_e o, logic sel);
    case (o)
      OPC_STOP, OPC_RDMSR, OPC_WRMSR, OPC_WRMSRD, OPC_IRET: return 1'b1;
      OPC_RDSPR, OPC_WRSPR:                                 return sel;
      default:                                              return 1'b0;
    endcase
  endfunction

  assign priv_op = needs_priv(opc, insn[SPR_SEL_BIT]);

  always_comb begin
    if (!valid || halted)          act = ACT_NONE;
    else if (priv_op && user_mode) act = ACT_TRAP_PRIV;
    else if (opc == OPC_STOP)      act = ACT_HALT;
    else if (mismatch)             act = ACT_TRAP_ILL;
    else                           act = ACT_RUN;
  end

endmodule

// File: rtl/priv_entry_calc.sv
module priv_entry_calc
  import priv_trap_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] CLR_MASK  = '0,
  parameter logic [XLEN-1:0] SET_MASK  = '0,
  parameter logic [XLEN-1:0] PRIV_MASK = '0,
  parameter logic [XLEN-1:0] ILL_MASK  = '0
) (
  input  act_e            act,
  input  logic [XLEN-1:0] msr_cur,
  output logic [XLEN-1:0] msr_entry,
  output logic [XLEN-1:0] srr1_entry
);

  function automatic logic [XLEN-1:0] supervisor_image(logic [XLEN-1:0] m);
    return (m & ~CLR_MASK) | SET_MASK;
  endfunction

  function automatic logic [XLEN-1:0] tagged_copy(logic [XLEN-1:0] m, act_e a);
    return m | ((a == ACT_TRAP_PRIV) ? PRIV_MASK : ILL_MASK);
  endfunction

  assign msr_entry  = supervisor_image(msr_cur);
  assign srr1_entry = tagged_copy(msr_cur, act);

endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
  import priv_trap_pkg::*;
#(
  parameter int              XLEN        = 64,
  parameter int              IW          = 32,
  parameter int              SPR_SEL_BIT = 20,
  parameter logic [XLEN-1:0] TRAP_ADDR   = 64'h700,
  parameter logic [XLEN-1:0] MSR_RST     = '0,
  parameter int BE_SF = 0,   parameter int BE_UND = 5,  parameter int BE_TES = 29,
  parameter int BE_TEE = 30, parameter int BE_TM = 31,  parameter int BE_VEC = 38,
  parameter int BE_VSX = 40, parameter int BE_EE = 48,  parameter int BE_PR = 49,
  parameter int BE_FP = 50,  parameter int BE_FE0 = 52, parameter int BE_FE1 = 55,
  parameter int BE_IR = 58,  parameter int BE_DR = 59,  parameter int BE_PMM = 61,
  parameter int BE_RI = 62,  parameter int BE_LE = 63,
  parameter int BE_CAUSE_ILL  = 44,
  parameter int BE_CAUSE_PRIV = 45
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  input  logic [2:0]      issue_op,
  input  logic [IW-1:0]   issue_insn,
  input  logic [XLEN-1:0] issue_cia,
  input  logic [XLEN-1:0] issue_nia,
  input  logic            issue_mismatch,
  input  logic            msr_wr_en,
  input  logic [XLEN-1:0] msr_wr_data,
  output logic [XLEN-1:0] next_pc,
  output logic            exec_go,
  output logic            trap_taken,
  output logic [XLEN-1:0] msr_q,
  output logic [XLEN-1:0] srr0_q,
  output logic [XLEN-1:0] srr1_q,
  output logic            halted
);

  function automatic logic [XLEN-1:0] be_bit(int p);
    return {{(XLEN-1){1'b0}}, 1'b1} << (XLEN - 1 - p);
  endfunction

  localparam int PR_IDX = XLEN - 1 - BE_PR;
  localparam int SF_IDX = XLEN - 1 - BE_SF;
  localparam int LE_IDX = XLEN - 1 - BE_LE;
  localparam logic [XLEN-1:0] CLR_MASK =
      be_bit(BE_UND) | be_bit(BE_TES) | be_bit(BE_TEE) | be_bit(BE_TM) |
      be_bit(BE_VEC) | be_bit(BE_VSX) | be_bit(BE_EE)  | be_bit(BE_PR) |
      be_bit(BE_FP)  | be_bit(BE_FE0) | be_bit(BE_FE1) | be_bit(BE_IR) |
      be_bit(BE_DR)  | be_bit(BE_PMM) | be_bit(BE_RI);
  localparam logic [XLEN-1:0] SET_MASK   = be_bit(BE_SF) | be_bit(BE_LE);
  localparam logic [XLEN-1:0] PRIV_MASK  = be_bit(BE_CAUSE_PRIV);
  localparam logic [XLEN-1:0] ILL_MASK   = be_bit(BE_CAUSE_ILL);
  localparam logic [XLEN-1:0] CAUSE_MASK = PRIV_MASK | ILL_MASK;

  act_e            act;
  logic            priv_op;
  logic            halt_req;
  logic [XLEN-1:0] msr_entry;
  logic [XLEN-1:0] srr1_entry;

  priv_classify #(.IW(IW), .SPR_SEL_BIT(SPR_SEL_BIT)) u_classify (
    .valid     (issue_valid),
    .op        (issue_op),
    .insn      (issue_insn),
    .user_mode (msr_q[PR_IDX]),
    .mismatch  (issue_mismatch),
    .halted    (halted),
    .priv_op   (priv_op),
    .act       (act)
  );

  priv_entry_calc #(
    .XLEN(XLEN), .CLR_MASK(CLR_MASK), .SET_MASK(SET_MASK),
    .PRIV_MASK(PRIV_MASK), .ILL_MASK(ILL_MASK)
  ) u_entry (
    .act        (act),
    .msr_cur    (msr_q),
    .msr_entry  (msr_entry),
    .srr1_entry (srr1_entry)
  );

  assign trap_taken = is_trap(act);
  assign exec_go    = (act == ACT_RUN);
  assign halt_req   = (act == ACT_HALT);

  always_comb begin
    if (trap_taken)   next_pc = TRAP_ADDR;
    else if (exec_go) next_pc = issue_nia;
    else              next_pc = issue_cia;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted <= 1'b0;
      msr_q  <= MSR_RST;
      srr0_q <= '0;
      srr1_q <= '0;
    end else if (trap_taken) begin
      srr0_q <= issue_cia;
      srr1_q <= srr1_entry;
      msr_q  <= msr_entry;
    end else if (halt_req) begin
      halted <= 1'b1;
    end else if (exec_go && msr_wr_en) begin
      msr_q <= msr_wr_data;
    end
  end

endmodule

// File: rtl/priv_trap_chk.sv
module priv_trap_chk #(
  parameter int              XLEN        = 64,
  parameter int              IW          = 32,
  parameter int              SPR_SEL_BIT = 20,
  parameter int              PR_IDX      = 14,
  parameter int              SF_IDX      = 63,
  parameter int              LE_IDX      = 0,
  parameter logic [XLEN-1:0] MSR_RST     = '0,
  parameter logic [XLEN-1:0] CAUSE_MASK  = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            issue_valid,
  input logic [2:0]      issue_op,
  input logic [IW-1:0]   issue_insn,
  input logic [XLEN-1:0] issue_cia,
  input logic            msr_wr_en,
  input logic [XLEN-1:0] msr_wr_data,
  input logic            exec_go,
  input logic            trap_taken,
  input logic [XLEN-1:0] msr_q,
  input logic [XLEN-1:0] srr0_q,
  input logic [XLEN-1:0] srr1_q,
  input logic            halted
);

  logic port_priv;
  assign port_priv = ((issue_op >= 3'd1) && (issue_op <= 3'd5)) ||
                     ((issue_op >= 3'd6) && issue_insn[SPR_SEL_BIT]);

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!halted && msr_q == MSR_RST)); // R1
  AST_PRIV_USER_TRAPS: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !halted && port_priv && msr_q[PR_IDX]) |-> trap_taken); // R2
  AST_SRR0_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    trap_taken |=> srr0_q == $past(issue_cia)); // R4
  AST_SRR1_COPY: assert property (@(posedge clk) disable iff (rst)
    trap_taken |=> ((srr1_q & ~CAUSE_MASK) == ($past(msr_q) & ~CAUSE_MASK)) && ($countones(srr1_q & CAUSE_MASK & ~$past(msr_q)) <= 1)); // R4
  AST_ENTRY_MSR: assert property (@(posedge clk) disable iff (rst)
    trap_taken |=> (!msr_q[PR_IDX] && msr_q[SF_IDX] && msr_q[LE_IDX])); // R5
  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_taken, exec_go, halted})); // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R8
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(msr_q) && $stable(srr0_q) && $stable(srr1_q))); // R8
  AST_MSR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (exec_go && msr_wr_en) |=> msr_q == $past(msr_wr_data)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> (!exec_go && !trap_taken)); // R11

endmodule

bind priv_trap_unit priv_trap_chk #(
  .XLEN(XLEN), .IW(IW), .SPR_SEL_BIT(SPR_SEL_BIT), .PR_IDX(PR_IDX),
  .SF_IDX(SF_IDX), .LE_IDX(LE_IDX), .MSR_RST(MSR_RST), .CAUSE_MASK(CAUSE_MASK)
) u_priv_trap_chk (
  .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
  .issue_insn(issue_insn), .issue_cia(issue_cia), .msr_wr_en(msr_wr_en),
  .msr_wr_data(msr_wr_data), .exec_go(exec_go), .trap_taken(trap_taken),
  .msr_q(msr_q), .srr0_q(srr0_q), .srr1_q(srr1_q), .halted(halted)
);

// File: tb/test_priv_trap_unit.sv
module test_priv_trap_unit;

  localparam logic [63:0] RST_IMG = 64'hC000;
  localparam logic [63:0] VEC     = 64'h700;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [2:0]  issue_op = '0;
  logic [31:0] issue_insn = '0;
  logic [63:0] issue_cia = '0;
  logic [63:0] issue_nia = '0;
  logic        issue_mismatch = 1'b0;
  logic        msr_wr_en = 1'b0;
  logic [63:0] msr_wr_data = '0;
  logic [63:0] next_pc, msr_q, srr0_q, srr1_q;
  logic        exec_go, trap_taken, halted;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [63:0] m_msr, m_srr0, m_srr1;
  logic        m_halt;

  int clr_be[15] = '{62, 59, 58, 55, 52, 50, 49, 48, 40, 38, 31, 30, 29, 5, 61};

  always #5 clk = ~clk;

  priv_trap_unit #(.MSR_RST(RST_IMG)) i_priv_trap_unit (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_insn(issue_insn), .issue_cia(issue_cia), .issue_nia(issue_nia),
    .issue_mismatch(issue_mismatch), .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
    .next_pc(next_pc), .exec_go(exec_go), .trap_taken(trap_taken), .msr_q(msr_q),
    .srr0_q(srr0_q), .srr1_q(srr1_q), .halted(halted)
  );

  function automatic logic [63:0] bm(int be);
    logic [63:0] r = '0;
    r[63 - be] = 1'b1;
    return r;
  endfunction

  function automatic logic privileged(logic [2:0] op, logic [31:0] w);
    if (op == 3'd6 || op == 3'd7) return w[20];
    return op != 3'd0;
  endfunction

  // 0 none, 1 proceed, 2 halt, 3 privileged interrupt, 4 illegal interrupt
  function automatic int outcome(logic v, logic [2:0] op, logic [31:0] w, logic mm);
    if (!v || m_halt) return 0;
    if (privileged(op, w) && m_msr[63 - 49]) return 3;
    if (op == 3'd1) return 2;
    if (mm) return 4;
    return 1;
  endfunction

  function automatic logic [63:0] entry_img(logic [63:0] m);
    logic [63:0] r = m;
    foreach (clr_be[k]) r[63 - clr_be[k]] = 1'b0;
    r[63] = 1'b1;
    r[0]  = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk(tag, "msr", msr_q, m_msr);
    chk(tag, "srr0", srr0_q, m_srr0);
    chk(tag, "srr1", srr1_q, m_srr1);
    chk(tag, "halted", {63'd0, halted}, {63'd0, m_halt});
  endtask

  task automatic step(input string tag, input logic v, input logic [2:0] op, input logic [31:0] w,
                      input logic mm, input logic we, input logic [63:0] wd);
    int o;
    logic [63:0] cia, nia, epc;
    cia = {32'd0, $urandom} & ~64'h3;
    nia = cia + 64'd4 + {48'd0, 16'($urandom) & 16'hFFFC};
    @(negedge clk);
    issue_valid = v; issue_op = op; issue_insn = w; issue_cia = cia;
    issue_nia = nia; issue_mismatch = mm; msr_wr_en = we; msr_wr_data = wd;
    #1;
    o = outcome(v, op, w, mm);
    epc = (o >= 3) ? VEC : (o == 1) ? nia : cia;
    chk(tag, "next_pc (R6)", next_pc, epc);
    chk(tag, "exec_go", {63'd0, exec_go}, {63'd0, o == 1});
    chk(tag, "trap_taken", {63'd0, trap_taken}, {63'd0, o >= 3});
    if (o >= 3) begin
      m_srr0 = cia;
      m_srr1 = m_msr | ((o == 3) ? bm(45) : bm(44));
      m_msr  = entry_img(m_msr);
    end else if (o == 2) m_halt = 1'b1;
    else if (o == 1 && we) m_msr = wd;
    @(posedge clk); #1;
    chk_regs(tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; issue_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
    m_msr = RST_IMG; m_srr0 = '0; m_srr1 = '0; m_halt = 1'b0;
    chk_regs("R1");
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    step("R2", 1, 3'd2, 32'h0, 0, 0, '0);                  // read-MSR in problem state
    step("R2", 1, 3'd7, 32'h0, 0, 1, 64'h4000);            // unprivileged SPR move, R9 write to user
    step("R2", 1, 3'd7, 32'h0010_0000, 0, 0, '0);          // privileged SPR move traps
    step("R9", 1, 3'd0, 32'h0, 0, 1, 64'h4000_1234);
    step("R2", 1, 3'd6, 32'h0, 0, 0, '0);
    step("R3", 1, 3'd0, 32'hABCD_0000, 1, 0, '0);          // illegal in problem state
    step("R10", 1, 3'd5, 32'h0, 1, 0, '0);                 // supervisor: illegal cause
    step("R9", 1, 3'd0, 32'h0, 0, 1, 64'h8000_0000_0000_4000);
    step("R10", 1, 3'd5, 32'h0, 1, 1, 64'h0);              // problem state: privileged cause, R9 write ignored
    step("R11", 0, 3'd2, 32'h0, 1, 1, 64'hFFFF);
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op = 3'($urandom);
      if (op == 3'd1) op = 3'd0;
      step("R5", ($urandom % 8) != 0, op, $urandom, ($urandom % 6) == 0,
           ($urandom % 4) == 0, {$urandom, $urandom});
    end
    step("R9", 1, 3'd0, 32'h0, 0, 1, 64'h4000);
    step("R7", 1, 3'd1, 32'h0, 0, 0, '0);                  // stop in problem state traps
    step("R7", 1, 3'd1, 32'h0, 1, 0, '0);                  // stop in supervisor halts
    step("R8", 1, 3'd0, 32'h0, 1, 1, 64'h55);
    step("R8", 1, 3'd2, 32'h0, 0, 1, 64'h4000);
    step("R8", 1, 3'd1, 32'h0, 0, 0, '0);
    step("R8", 0, 3'd0, 32'h0, 0, 0, '0);
    do_reset();
    step("R4", 1, 3'd4, 32'h0, 0, 0, '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule